// File: doc/BRIEF.md
# 16-bit SEC-DED Memory Error Corrector

This unit sits between a processor and a memory of 16-bit words and protects each word with six check bits. When a word is written, the unit computes the six check bits from the data so that they can be stored next to it. When a word is read, the unit captures the 22 stored bits and recomputes the check bits. The recomputed bits, XORed with the stored check bits, form a six-bit syndrome. The unit uses that syndrome to decide between a clean word, a correctable error and an uncorrectable error.

The code gives every data bit a distinct odd-weight column of weight three. Every check bit gets a weight-one column. A flipped data bit is repaired. A flipped check bit is reported but the data is passed on untouched. Any syndrome that does not point at exactly one stored bit raises the double-error flag, and in that case the data is passed on uncorrected. A two-bit mode input picks what the unit drives. The syndrome is driven on the same check output that carries the generated check bits in write mode. The pad-level direction control is modelled as separate input and output vectors, each output vector with an enable.

Top module: `secded16_edac`

## Requirements
- R1: In mode 00 (generate), check_out equals the check bits of data_in, check_oe is 1, data_oe is 0, and both flags are 0. Data bit i uses as its column the i-th value (counting from 0), in ascending numeric order, among the six-bit values with exactly three ones. Check bit j is the XOR of every data bit whose column has bit j set.
- R2: In mode 01 (read), a rising clock edge with cap_en high stores data_in and check_in. With cap_en low, or in any other mode, the stored word is held. In mode 01 both enables and both flags are 0.
- R3: In modes 10 and 11, check_out carries the syndrome: the check bits recomputed from the stored data, XORed with the stored check bits. check_oe is 1. A stored word with a zero syndrome raises neither flag.
- R4: A single flipped data bit i gives a syndrome equal to column i and raises sef. In mode 11, data_out is the stored data with bit i flipped back.
- R5: A single flipped check bit j gives the syndrome 1<<j and raises sef. In mode 11, data_out equals the stored data unchanged.
- R6: Any two flipped bits give a nonzero even-weight syndrome and raise def. In mode 11, data_out equals the stored, uncorrected data.
- R7: An odd-weight syndrome that matches no column (one of the four unused weight-three values, or any weight-five value) raises def and leaves the data uncorrected.
- R8: sef and def are never both 1. data_oe is 1 only in mode 11, where data_out is driven. In every other mode data_out is 0.
- R9: A synchronous active-high reset clears the stored word, so that mode 11 then shows data 0, syndrome 0 and no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 generate, 01 read, 10 diagnose, 11 correct |
| cap_en | input | 1 | Capture enable for read mode |
| data_in | input | 16 | Data from the processor or the memory |
| check_in | input | 6 | Check bits from the memory |
| data_out | output | 16 | Corrected data (mode 11) |
| data_oe | output | 1 | Drive enable for data_out |
| check_out | output | 6 | Generated check bits or syndrome |
| check_oe | output | 1 | Drive enable for check_out |
| sef | output | 1 | Single-error flag |
| def | output | 1 | Double or uncorrectable error flag |

## Verification
The bench builds the unit with its default 16 data bits and 6 check bits, a size small enough for a full sweep. For each of six data words it injects every one of the 22 single-bit errors and all 231 two-bit error pairs. It checks the syndrome, the flags and the corrected data against a code table that the bench computes for itself. Hand-picked triple errors reach the unused weight-three syndromes and a weight-five syndrome. One of them also reaches a miscorrection onto data bit 0.

// File: rtl/edac_pkg.sv
package edac_pkg;

    parameter int unsigned DW = 16;
    parameter int unsigned CW = 6;

    typedef enum logic [1:0] {
        MODE_GEN  = 2'b00,
        MODE_READ = 2'b01,
        MODE_DIAG = 2'b10,
        MODE_CORR = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_CLEAN,
        ST_DATA_ERR,
        ST_CHECK_ERR,
        ST_MULTI_ERR
    } status_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] chk;
    } word_t;

    function automatic int popcnt(input int v);
        int n;
        n = 0;
        for (int b = 0; b < 32; b++) n += (v >> b) & 1;
        return n;
    endfunction

    // Column of data bit idx: odd-weight codes of weight >= 3 in ascending order.
    function automatic logic [CW-1:0] data_column(input int idx);
        int seen;
        logic [CW-1:0] r;
        seen = 0;
        r = '0;
        for (int w = 3; w <= int'(CW); w += 2) begin
            for (int v = 1; v < (1 << CW); v++) begin
                if (popcnt(v) == w) begin
                    if (seen == idx) r = v[CW-1:0];
                    seen++;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/edac_parity_gen.sv
module edac_parity_gen
    import edac_pkg::*;
#(
    parameter int unsigned D_W = DW,
    parameter int unsigned C_W = CW
) (
    input  logic [D_W-1:0] data,
    output logic [C_W-1:0] check
);
    logic [C_W-1:0] term [D_W];

    for (genvar i = 0; i < D_W; i++) begin : g_term
        localparam logic [C_W-1:0] COL = C_W'(data_column(i));
        assign term[i] = data[i] ? COL : '0;
    end

    always_comb begin
        check = '0;
        for (int i = 0; i < int'(D_W); i++) check ^= term[i];
    end
endmodule

// File: rtl/edac_word_reg.sv
module edac_word_reg
    import edac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t d,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/edac_syndrome_dec.sv
module edac_syndrome_dec
    import edac_pkg::*;
#(
    parameter int unsigned D_W = DW,
    parameter int unsigned C_W = CW
) (
    input  word_t          stored,
    output logic [C_W-1:0] syndrome,
    output logic [D_W-1:0] fixed,
    output status_e        status
);
    logic [C_W-1:0] regen;
    logic [D_W-1:0] hit;

    edac_parity_gen #(.D_W(D_W), .C_W(C_W)) u_regen (
        .data  (stored.data),
        .check (regen)
    );

    assign syndrome = regen ^ stored.chk;

    for (genvar i = 0; i < D_W; i++) begin : g_hit
        localparam logic [C_W-1:0] COL = C_W'(data_column(i));
        assign hit[i] = (syndrome == COL);
    end

    always_comb begin
        fixed = stored.data ^ hit;
        if (syndrome == '0)         status = ST_CLEAN;
        else if (|hit)              status = ST_DATA_ERR;
        else if ($onehot(syndrome)) status = ST_CHECK_ERR;
        else                        status = ST_MULTI_ERR;
    end
endmodule

// File: rtl/secded16_edac.sv
module secded16_edac
    import edac_pkg::*;
#(
    parameter int unsigned DATA_W = DW,
    parameter int unsigned CHK_W  = CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  check_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [CHK_W-1:0]  check_out,
    output logic              check_oe,
    output logic              sef,
    output logic              def
);
    mode_e          mode_q;
    word_t          cap_d, word_q;
    logic [CHK_W-1:0]  gen_chk, syn;
    logic [DATA_W-1:0] fixed;
    status_e        status;
    logic           load;

    assign mode_q = mode_e'(mode);
    assign load   = (mode_q == MODE_READ) && cap_en;
    assign cap_d  = '{data: data_in, chk: check_in};

    edac_parity_gen #(.D_W(DATA_W), .C_W(CHK_W)) u_gen (
        .data  (data_in),
        .check (gen_chk)
    );

    edac_word_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (cap_d),
        .q    (word_q)
    );

    edac_syndrome_dec #(.D_W(DATA_W), .C_W(CHK_W)) u_dec (
        .stored   (word_q),
        .syndrome (syn),
        .fixed    (fixed),
        .status   (status)
    );

    always_comb begin
        data_out  = '0;
        data_oe   = 1'b0;
        check_out = '0;
        check_oe  = 1'b0;
        sef       = 1'b0;
        def       = 1'b0;
        case (mode_q)
            MODE_GEN: begin
                check_out = gen_chk;
                check_oe  = 1'b1;
            end
            MODE_READ: ;
            MODE_DIAG, MODE_CORR: begin
                check_out = syn;
                check_oe  = 1'b1;
                sef = (status == ST_DATA_ERR) || (status == ST_CHECK_ERR);
                def = (status == ST_MULTI_ERR);
                if (mode_q == MODE_CORR) begin
                    data_out = fixed;
                    data_oe  = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/secded16_edac_checker.sv
module secded16_edac_checker
    import edac_pkg::*;
#(
    parameter int unsigned DATA_W = DW,
    parameter int unsigned CHK_W  = CW
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              cap_en,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic [CHK_W-1:0]  check_out,
    input logic              check_oe,
    input logic              sef,
    input logic              def
);
    logic [DATA_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (mode == MODE_READ && cap_en) seen_q <= data_in;
    end

    a_r1_gen_drive: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_GEN) |-> (check_oe && !data_oe && !sef && !def));

    a_r2_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_READ) |-> (!check_oe && !data_oe && !sef && !def));

    a_r3_clean_word: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CORR && check_out == '0) |-> (!sef && !def && data_out == seen_q));

    a_r4_one_bit_fixed: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CORR && sef && !$onehot(check_out)) |-> ($countones(data_out ^ seen_q) == 1));

    a_r5_check_err_passes: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CORR && sef && $onehot(check_out)) |-> (data_out == seen_q));

    a_r6_uncorrected: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CORR && def) |-> (data_out == seen_q && check_out != '0));

    a_r8_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(sef && def));

    a_r8_data_drive: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_CORR) |-> (!data_oe && data_out == '0));
endmodule

bind secded16_edac secded16_edac_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .cap_en    (cap_en),
    .data_in   (data_in),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .check_out (check_out),
    .check_oe  (check_oe),
    .sef       (sef),
    .def       (def)
);

// File: tb/secded16_edac_tb.sv
module secded16_edac_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        cap_en = 1'b0;
    logic [15:0] data_in = '0;
    logic [5:0]  check_in = '0;
    logic [15:0] data_out;
    logic        data_oe;
    logic [5:0]  check_out;
    logic        check_oe;
    logic        sef, def;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded16_edac u_dut (
        .clk(clk), .rst(rst), .mode(mode), .cap_en(cap_en),
        .data_in(data_in), .check_in(check_in),
        .data_out(data_out), .data_oe(data_oe),
        .check_out(check_out), .check_oe(check_oe),
        .sef(sef), .def(def)
    );

    logic [5:0]  col [16];
    logic [15:0] words [NW];

    function automatic logic [5:0] ref_check(input logic [15:0] d);
        logic [5:0] c;
        c = '0;
        for (int i = 0; i < 16; i++) if (d[i]) c ^= col[i];
        return c;
    endfunction

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [15:0] d, input logic [5:0] c);
        @(negedge clk);
        mode = 2'b01; cap_en = 1'b1; data_in = d; check_in = c;
        #1;
        expect_eq("R2 read-mode outputs quiet", {28'd0, check_oe, data_oe, sef, def}, 32'd0);
        @(negedge clk);
        cap_en = 1'b0; mode = 2'b11; data_in = ~d;
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        logic [15:0] d, de;
        logic [5:0]  c, ce, syn;
        int n;
        n = 0;
        for (int v = 1; v < 64; v++) begin
            if ($countones(6'(v)) == 3 && n < 16) begin
                col[n] = 6'(v);
                n++;
            end
        end
        words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hA5C3;
        words[3] = 16'h1234; words[4] = 16'h8001; words[5] = 16'h7E5A;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        mode = 2'b11;
        #1;
        // R9: reset state
        expect_eq("R9 reset data", {16'd0, data_out}, 32'd0);
        expect_eq("R9 reset syndrome/flags", {24'd0, check_out, sef, def}, 32'd0);

        // R1: generate mode
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            mode = 2'b00; data_in = words[w];
            #1;
            expect_eq("R1 generated check", {26'd0, check_out}, {26'd0, ref_check(words[w])});
            expect_eq("R1 enables/flags", {28'd0, check_oe, data_oe, sef, def}, 32'h8);
        end

        for (int w = 0; w < NW; w++) begin
            d = words[w];
            c = ref_check(d);
            // R3 clean
            capture(d, c);
            expect_eq("R3 clean syndrome/flags", {24'd0, check_out, sef, def}, 32'd0);
            expect_eq("R3 clean data", {16'd0, data_out}, {16'd0, d});
            // R4 / R5 every single error
            for (int p = 0; p < 22; p++) begin
                de = d; ce = c;
                if (p < 16) de[p] = ~de[p]; else ce[p-16] = ~ce[p-16];
                capture(de, ce);
                if (p < 16) begin
                    expect_eq("R4 syndrome", {26'd0, check_out}, {26'd0, col[p]});
                    expect_eq("R4 corrected data", {16'd0, data_out}, {16'd0, d});
                    expect_eq("R4 flags", {30'd0, sef, def}, 32'd2);
                end else begin
                    expect_eq("R5 syndrome", {26'd0, check_out}, 32'(1) << (p-16));
                    expect_eq("R5 data unchanged", {16'd0, data_out}, {16'd0, d});
                    expect_eq("R5 flags", {30'd0, sef, def}, 32'd2);
                end
            end
            // R6 all double errors
            for (int a = 0; a < 22; a++) begin
                for (int b = a + 1; b < 22; b++) begin
                    de = d; ce = c;
                    if (a < 16) de[a] = ~de[a]; else ce[a-16] = ~ce[a-16];
                    if (b < 16) de[b] = ~de[b]; else ce[b-16] = ~ce[b-16];
                    syn = ref_check(de) ^ ce;
                    capture(de, ce);
                    expect_eq("R6 syndrome", {26'd0, check_out}, {26'd0, syn});
                    expect_eq("R6 flags", {30'd0, sef, def}, 32'd1);
                    expect_eq("R6 uncorrected data", {16'd0, data_out}, {16'd0, de});
                end
            end
        end

        // R7: unused weight-three syndrome 56 (check bits 3,4,5 flipped)
        d = 16'h5A5A; c = ref_check(d);
        capture(d, c ^ 6'b111000);
        expect_eq("R7 syndrome 56", {26'd0, check_out}, 32'd56);
        expect_eq("R7 flags for 56", {30'd0, sef, def}, 32'd1);
        expect_eq("R7 data for 56", {16'd0, data_out}, {16'd0, d});
        // R7: weight-five syndrome 31
        capture(d, c ^ 6'b011111);
        expect_eq("R7 syndrome 31", {26'd0, check_out}, 32'd31);
        expect_eq("R7 flags for 31", {30'd0, sef, def}, 32'd1);
        expect_eq("R7 data for 31", {16'd0, data_out}, {16'd0, d});
        // R4 corner: three check flips alias column 0 (value 7) -> data bit 0 flipped
        capture(d, c ^ 6'b000111);
        expect_eq("R4 alias flags", {30'd0, sef, def}, 32'd2);
        expect_eq("R4 alias data", {16'd0, data_out}, {16'd0, d ^ 16'h0001});

        // R2: hold when cap_en low
        d = 16'hC0DE; c = ref_check(d);
        capture(d, c);
        @(negedge clk);
        mode = 2'b01; cap_en = 1'b0; data_in = 16'h1111; check_in = 6'h2A;
        @(negedge clk);
        mode = 2'b11;
        #1;
        expect_eq("R2 hold data", {16'd0, data_out}, {16'd0, d});
        expect_eq("R2 hold syndrome", {26'd0, check_out}, 32'd0);

        // R8: diagnose mode drives syndrome, not data
        capture(d ^ 16'h0010, c);
        @(negedge clk);
        mode = 2'b10;
        #1;
        expect_eq("R8 diag data_oe/data", {15'd0, data_oe, data_out}, 32'd0);
        expect_eq("R8 diag flags/oe", {29'd0, check_oe, sef, def}, 32'd6);
        expect_eq("R3 diag syndrome", {26'd0, check_out}, {26'd0, col[4]});

        // R9: reset clears stored word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; mode = 2'b11;
        #1;
        expect_eq("R9 cleared word", {10'd0, data_out, check_out}, 32'd0);

        finish_run();
    end
endmodule